// File: doc/BRIEF.md
# Bridge Interrupt Status Aggregator

This block gathers error and completion events from three parts of a bus bridge and turns them into three interrupt requests for the system interrupt controller. The three sources are a host-side initiator, a packet transmit path and a packet receive path. Each event arrives as a one-cycle pulse. The pulse sets a sticky status bit. That bit is combined with a software-controlled enable bit, and the result drives a registered interrupt line.

Software reaches the enables and status bits through a small word-addressed register port. Writes take effect on the clock edge. Reads are combinational on the address. Status bits are cleared by writing 1 to them.

The bus-error condition belongs to both the transmit and receive groups. It is stored as a single status flop and a single enable flop, and both register groups show and write it. The four shared external interrupt lines of the bridge are held in their inactive (high) state.

Top module: `bridge_irq_agg`

## Requirements
- R1: While `rst` is high at a clock edge, every status and enable bit is cleared and `irq_init`, `irq_tx` and `irq_rx` are low from the following cycle.
- R2: A pulse on an event input sets its status bit at that clock edge. The bit then stays set until software clears it. The initiator status word is at byte offset 0x4: bit 0 master abort, bit 1 target abort, bit 2 retry limit. The event input `ev_init` uses the same bit order.
- R3: Writing to a status word clears each bit written as 1. Bits written as 0 keep their value.
- R4: When an event pulse and a clear by write for the same status bit fall in the same cycle, the bit ends up set.
- R5: The enable words read back what was written. Their offsets are: initiator 0x0 (bits 2:0, same order as R2), transmit 0x8 and receive 0x10. In the transmit and receive words, bit 0 is normal completion, bit 1 is FIFO error and bit 2 is bus error. The inputs `ev_tx` and `ev_rx` use bit 0 for completion and bit 1 for FIFO error.
- R6: The bus-error enable is one bit. It is shown at bit 2 of both 0x8 and 0x10, and a write to either word sets or clears it for both views.
- R7: The bus-error status is one bit, set by `ev_bus_err`. It is shown at bit 2 of the transmit status word (0xC) and of the receive status word (0x14). A write-1 clear through either word clears it in both.
- R8: Each interrupt output equals the OR of (status AND enable) over its own sources, delayed by exactly one clock from the status and enable registers.
- R9: When the shared bus-error status and the shared bus-error enable are both set, `irq_tx` and `irq_rx` are both asserted.
- R10: Offsets 0x18 and 0x1C read as zero, and writes to them change no register.
- R11: `ext_irq_n` is 4'b1111 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_init | input | 3 | Initiator event pulses: [0] master abort, [1] target abort, [2] retry limit |
| ev_tx | input | 2 | Transmit event pulses: [0] completion, [1] FIFO error |
| ev_rx | input | 2 | Receive event pulses: [0] completion, [1] FIFO error |
| ev_bus_err | input | 1 | Shared bus-error event pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| irq_init | output | 1 | Initiator interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |
| ext_irq_n | output | 4 | Shared external interrupt lines, held inactive high |

## Verification
Two functions can fall in the same cycle: an event pulse setting a status bit, and a software write-1 clearing that same bit. The bench provokes this on purpose with an initiator event issued together with a clear of the same bit, and it expects the bit to read back set. The random phase of the bench then issues events and writes with independent probabilities, so such collisions also happen on the transmit, receive and shared bus-error bits. A behavioural model applies the "set wins" rule in every cycle, and the bench compares the read data and the three interrupt lines against that model.

// File: rtl/bia_pkg.sv
package bia_pkg;

    localparam int INIT_SRC_N = 3;
    localparam int PATH_SRC_N = 2;

    // Word indices (byte offset / 4) of the register map
    localparam int IDX_INIT_EN = 0;
    localparam int IDX_INIT_ST = 1;
    localparam int IDX_TX_EN   = 2;
    localparam int IDX_TX_ST   = 3;
    localparam int IDX_RX_EN   = 4;
    localparam int IDX_RX_ST   = 5;

    // One bit per interrupt source; used for both the enable and status banks
    typedef struct packed {
        logic                  berr;
        logic [PATH_SRC_N-1:0] rx;
        logic [PATH_SRC_N-1:0] tx;
        logic [INIT_SRC_N-1:0] init;
    } ctl_t;

    localparam int CTL_W  = $bits(ctl_t);
    localparam int VIEW_W = PATH_SRC_N + 1;

    // Transmit or receive view: shared bus-error bit above the path bits
    function automatic logic [VIEW_W-1:0] path_view(input logic berr,
                                                    input logic [PATH_SRC_N-1:0] path);
        return {berr, path};
    endfunction

endpackage

// File: rtl/bia_wdec.sv
module bia_wdec
    import bia_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [VIEW_W-1:0] wbits_i,
    output ctl_t             st_clr_o,
    output ctl_t             en_ld_o,
    output ctl_t             en_val_o
);

    always_comb begin
        st_clr_o = '0;
        en_ld_o  = '0;
        en_val_o = '0;
        if (we_i) begin
            case (idx_i)
                IDX_W'(IDX_INIT_EN): begin
                    en_ld_o.init  = '1;
                    en_val_o.init = wbits_i[INIT_SRC_N-1:0];
                end
                IDX_W'(IDX_INIT_ST): begin
                    st_clr_o.init = wbits_i[INIT_SRC_N-1:0];
                end
                IDX_W'(IDX_TX_EN): begin
                    en_ld_o.tx    = '1;
                    en_ld_o.berr  = 1'b1;
                    en_val_o.tx   = wbits_i[PATH_SRC_N-1:0];
                    en_val_o.berr = wbits_i[PATH_SRC_N];
                end
                IDX_W'(IDX_TX_ST): begin
                    st_clr_o.tx   = wbits_i[PATH_SRC_N-1:0];
                    st_clr_o.berr = wbits_i[PATH_SRC_N];
                end
                IDX_W'(IDX_RX_EN): begin
                    en_ld_o.rx    = '1;
                    en_ld_o.berr  = 1'b1;
                    en_val_o.rx   = wbits_i[PATH_SRC_N-1:0];
                    en_val_o.berr = wbits_i[PATH_SRC_N];
                end
                IDX_W'(IDX_RX_ST): begin
                    st_clr_o.rx   = wbits_i[PATH_SRC_N-1:0];
                    st_clr_o.berr = wbits_i[PATH_SRC_N];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bia_bank.sv
module bia_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    // Per-bit flop: a set in the same cycle as a clear leaves the bit set
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q_o[b] <= 1'b0;
            end else if (set_i[b]) begin
                q_o[b] <= 1'b1;
            end else if (clr_i[b]) begin
                q_o[b] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bia_irq_line.sv
module bia_irq_line #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] st_i,
    input  logic [W-1:0] en_i,
    output logic         irq_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |(st_i & en_i);
        end
    end

endmodule

// File: rtl/bia_rdmux.sv
module bia_rdmux
    import bia_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  ctl_t              st_i,
    input  ctl_t              en_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int PAD_V = DATA_W - VIEW_W;
    localparam int PAD_I = DATA_W - INIT_SRC_N;

    always_comb begin
        case (idx_i)
            IDX_W'(IDX_INIT_EN): rdata_o = {{PAD_I{1'b0}}, en_i.init};
            IDX_W'(IDX_INIT_ST): rdata_o = {{PAD_I{1'b0}}, st_i.init};
            IDX_W'(IDX_TX_EN):   rdata_o = {{PAD_V{1'b0}}, path_view(en_i.berr, en_i.tx)};
            IDX_W'(IDX_TX_ST):   rdata_o = {{PAD_V{1'b0}}, path_view(st_i.berr, st_i.tx)};
            IDX_W'(IDX_RX_EN):   rdata_o = {{PAD_V{1'b0}}, path_view(en_i.berr, en_i.rx)};
            IDX_W'(IDX_RX_ST):   rdata_o = {{PAD_V{1'b0}}, path_view(st_i.berr, st_i.rx)};
            default:             rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/bridge_irq_agg.sv
module bridge_irq_agg
    import bia_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [INIT_SRC_N-1:0] ev_init,
    input  logic [PATH_SRC_N-1:0] ev_tx,
    input  logic [PATH_SRC_N-1:0] ev_rx,
    input  logic                  ev_bus_err,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  irq_init,
    output logic                  irq_tx,
    output logic                  irq_rx,
    output logic [3:0]            ext_irq_n
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    ctl_t             st_q, en_q;
    ctl_t             st_clr, en_ld, en_val;
    ctl_t             ev_vec;
    logic             port_unused;

    assign word_idx    = reg_addr[ADDR_W-1:2];
    assign port_unused = ^{reg_addr[1:0], reg_wdata[DATA_W-1:VIEW_W]};

    assign ev_vec.init = ev_init;
    assign ev_vec.tx   = ev_tx;
    assign ev_vec.rx   = ev_rx;
    assign ev_vec.berr = ev_bus_err;

    bia_wdec #(.IDX_W(IDX_W)) u_wdec (
        .we_i     (reg_we),
        .idx_i    (word_idx),
        .wbits_i  (reg_wdata[VIEW_W-1:0]),
        .st_clr_o (st_clr),
        .en_ld_o  (en_ld),
        .en_val_o (en_val)
    );

    // Status bank: events set, write-1 clears
    bia_bank #(.W(CTL_W)) u_status (
        .clk   (clk),
        .rst   (rst),
        .set_i (ev_vec),
        .clr_i (st_clr),
        .q_o   (st_q)
    );

    // Enable bank: a loaded field takes the written value
    bia_bank #(.W(CTL_W)) u_enable (
        .clk   (clk),
        .rst   (rst),
        .set_i (en_ld & en_val),
        .clr_i (en_ld & ~en_val),
        .q_o   (en_q)
    );

    bia_irq_line #(.W(INIT_SRC_N)) u_irq_init (
        .clk   (clk),
        .rst   (rst),
        .st_i  (st_q.init),
        .en_i  (en_q.init),
        .irq_o (irq_init)
    );

    bia_irq_line #(.W(VIEW_W)) u_irq_tx (
        .clk   (clk),
        .rst   (rst),
        .st_i  (path_view(st_q.berr, st_q.tx)),
        .en_i  (path_view(en_q.berr, en_q.tx)),
        .irq_o (irq_tx)
    );

    bia_irq_line #(.W(VIEW_W)) u_irq_rx (
        .clk   (clk),
        .rst   (rst),
        .st_i  (path_view(st_q.berr, st_q.rx)),
        .en_i  (path_view(en_q.berr, en_q.rx)),
        .irq_o (irq_rx)
    );

    bia_rdmux #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rdmux (
        .idx_i   (word_idx),
        .st_i    (st_q),
        .en_i    (en_q),
        .rdata_o (reg_rdata)
    );

    assign ext_irq_n = '1;

endmodule

// File: rtl/bia_checker.sv
module bia_checker
    import bia_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic [INIT_SRC_N-1:0] ev_init,
    input logic [PATH_SRC_N-1:0] ev_tx,
    input logic [PATH_SRC_N-1:0] ev_rx,
    input logic                  ev_bus_err,
    input logic                  reg_we,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic [DATA_W-1:0]     reg_rdata,
    input logic                  irq_init,
    input logic                  irq_tx,
    input logic                  irq_rx,
    input ctl_t                  st,
    input ctl_t                  en
);

    logic [CTL_W-1:0] evv;
    assign evv = {ev_bus_err, ev_rx, ev_tx, ev_init};

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!irq_init && !irq_tx && !irq_rx && st == '0 && en == '0)); // R1

    AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (evv != '0) |=> ((st & $past(evv)) == $past(evv))); // R2

    AST_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> (($past(st) & ~st) == '0)); // R3

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (reg_we && evv != '0) |=> ((st & $past(evv)) == $past(evv))); // R4

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq_init |-> $past(|(st.init & en.init))); // R8

    AST_BERR_BOTH_LINES: assert property (@(posedge clk) disable iff (rst)
        (st.berr && en.berr) |=> (irq_tx && irq_rx)); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[ADDR_W-1:2] >= (ADDR_W-2)'(6)) |-> (reg_rdata == '0)); // R10

endmodule

bind bridge_irq_agg bia_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ev_init    (ev_init),
    .ev_tx      (ev_tx),
    .ev_rx      (ev_rx),
    .ev_bus_err (ev_bus_err),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .irq_init   (irq_init),
    .irq_tx     (irq_tx),
    .irq_rx     (irq_rx),
    .st         (st_q),
    .en         (en_q)
);

// File: tb/bridge_irq_agg_tb.sv
`timescale 1ns/100ps
module bridge_irq_agg_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  ev_init = '0;
    logic [1:0]  ev_tx = '0;
    logic [1:0]  ev_rx = '0;
    logic        ev_bus_err = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_init, irq_tx, irq_rx;
    logic [3:0]  ext_irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit live = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bridge_irq_agg u_dut (
        .clk(clk), .rst(rst), .ev_init(ev_init), .ev_tx(ev_tx), .ev_rx(ev_rx),
        .ev_bus_err(ev_bus_err), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_init(irq_init),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .ext_irq_n(ext_irq_n)
    );

    // ---------------- behavioural reference model ----------------
    logic [2:0] m_ien, m_ist;
    logic [1:0] m_ten, m_tst, m_ren, m_rst;
    logic       m_ben, m_bst;
    logic       m_irq_i, m_irq_t, m_irq_r;
    logic [2:0] t_ist;
    logic [1:0] t_tst, t_rst;
    logic       t_bst;

    function automatic logic [31:0] model_read(input logic [4:0] a);
        case (a[4:2])
            3'd0:    return {29'd0, m_ien};
            3'd1:    return {29'd0, m_ist};
            3'd2:    return {29'd0, m_ben, m_ten};
            3'd3:    return {29'd0, m_bst, m_tst};
            3'd4:    return {29'd0, m_ben, m_ren};
            3'd5:    return {29'd0, m_bst, m_rst};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string read_tag(input logic [4:0] a);
        case (a[4:2])
            3'd0, 3'd2, 3'd4: return "R5/R6 enable read";
            3'd1:             return "R2/R3/R4 init status read";
            3'd3, 3'd5:       return "R7 path status read";
            default:          return "R10 unmapped read";
        endcase
    endfunction

    always @(posedge clk) begin
        live <= 1'b1;
        if (rst) begin
            m_ien <= '0; m_ist <= '0; m_ten <= '0; m_tst <= '0;
            m_ren <= '0; m_rst <= '0; m_ben <= 1'b0; m_bst <= 1'b0;
            m_irq_i <= 1'b0; m_irq_t <= 1'b0; m_irq_r <= 1'b0;
        end else begin
            m_irq_i <= (m_ist & m_ien) != 0;
            m_irq_t <= ((m_tst & m_ten) != 0) || (m_bst && m_ben);
            m_irq_r <= ((m_rst & m_ren) != 0) || (m_bst && m_ben);
            t_ist = m_ist; t_tst = m_tst; t_rst = m_rst; t_bst = m_bst;
            if (reg_we) begin
                case (reg_addr[4:2])
                    3'd0: m_ien <= reg_wdata[2:0];
                    3'd1: t_ist = t_ist & ~reg_wdata[2:0];
                    3'd2: begin m_ten <= reg_wdata[1:0]; m_ben <= reg_wdata[2]; end
                    3'd3: begin t_tst = t_tst & ~reg_wdata[1:0]; if (reg_wdata[2]) t_bst = 1'b0; end
                    3'd4: begin m_ren <= reg_wdata[1:0]; m_ben <= reg_wdata[2]; end
                    3'd5: begin t_rst = t_rst & ~reg_wdata[1:0]; if (reg_wdata[2]) t_bst = 1'b0; end
                    default: ;
                endcase
            end
            m_ist <= t_ist | ev_init;
            m_tst <= t_tst | ev_tx;
            m_rst <= t_rst | ev_rx;
            m_bst <= t_bst | ev_bus_err;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (live && !done) begin
            chk("R8 irq_init vs model", 32'(irq_init), 32'(m_irq_i));
            chk("R8 irq_tx vs model", 32'(irq_tx), 32'(m_irq_t));
            chk("R8 irq_rx vs model", 32'(irq_rx), 32'(m_irq_r));
            chk(read_tag(reg_addr), reg_rdata, model_read(reg_addr));
            chk("R11 ext lines idle", 32'(ext_irq_n), 32'hF);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc();
        @(posedge clk);
        #1;
        ev_init = '0; ev_tx = '0; ev_rx = '0; ev_bus_err = 1'b0; reg_we = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        cyc();
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        reg_addr = a;
        #0.2;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        ev_init = 3'b111; ev_bus_err = 1'b1;
        cyc(); cyc(); cyc();
        for (int a = 0; a < 8; a++) rd_chk("R1 reset read", 5'(a * 4), 32'd0);
        chk("R1 irq_init after reset", 32'(irq_init), 0);
        chk("R1 irq_tx after reset", 32'(irq_tx), 0);
        chk("R1 irq_rx after reset", 32'(irq_rx), 0);
        rst = 1'b0;
        cyc();

        // R2: event sets sticky status
        ev_init = 3'b100; cyc();
        rd_chk("R2 retry status set", 5'h04, 32'h4);
        cyc(); cyc();
        rd_chk("R2 retry status held", 5'h04, 32'h4);

        // R3: write-1-to-clear
        wr(5'h04, 32'h0);
        rd_chk("R3 zero write keeps bit", 5'h04, 32'h4);
        wr(5'h04, 32'h4);
        rd_chk("R3 one write clears bit", 5'h04, 32'h0);

        // R5 + R8: enable and one-cycle interrupt lag
        wr(5'h00, 32'h7);
        rd_chk("R5 init enable readback", 5'h00, 32'h7);
        ev_init = 3'b001; cyc();
        chk("R8 irq_init not yet", 32'(irq_init), 0);
        cyc();
        chk("R8 irq_init one clock later", 32'(irq_init), 1);
        wr(5'h04, 32'h1);
        chk("R8 irq_init holds one clock after clear", 32'(irq_init), 1);
        cyc();
        chk("R8 irq_init falls", 32'(irq_init), 0);

        // R4: set wins over clear in the same cycle
        ev_init = 3'b010; wr(5'h04, 32'h2);
        rd_chk("R4 set beats clear", 5'h04, 32'h2);
        wr(5'h04, 32'h2);
        rd_chk("R4 later clear works", 5'h04, 32'h0);

        // R6: shared bus-error enable
        wr(5'h08, 32'h4);
        rd_chk("R6 berr enable seen via rx word", 5'h10, 32'h4);
        wr(5'h10, 32'h3);
        rd_chk("R6 berr enable cleared via rx word", 5'h08, 32'h0);
        rd_chk("R5 rx enable readback", 5'h10, 32'h3);

        // R7 + R9: shared bus-error status and both lines
        wr(5'h10, 32'h0);
        wr(5'h08, 32'h4);
        ev_bus_err = 1'b1; cyc();
        rd_chk("R7 berr status tx view", 5'h0C, 32'h4);
        rd_chk("R7 berr status rx view", 5'h14, 32'h4);
        cyc();
        chk("R9 irq_tx from bus error", 32'(irq_tx), 1);
        chk("R9 irq_rx from bus error", 32'(irq_rx), 1);
        wr(5'h14, 32'h4);
        rd_chk("R7 clear via rx clears tx view", 5'h0C, 32'h0);

        // R10: unmapped offsets
        wr(5'h18, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd_chk("R10 unmapped 0x18 reads zero", 5'h18, 32'h0);
        rd_chk("R10 unmapped 0x1C reads zero", 5'h1C, 32'h0);
        rd_chk("R10 no side effect on init enable", 5'h00, 32'h7);
        rd_chk("R10 no side effect on init status", 5'h04, 32'h0);

        // Random mix: collisions of events and clears on every bit (R4, R7, R8)
        for (int i = 0; i < 4000; i++) begin
            ev_init    = ($urandom % 6 == 0) ? 3'($urandom) : 3'd0;
            ev_tx      = ($urandom % 6 == 0) ? 2'($urandom) : 2'd0;
            ev_rx      = ($urandom % 6 == 0) ? 2'($urandom) : 2'd0;
            ev_bus_err = ($urandom % 10 == 0);
            reg_we     = ($urandom % 3 == 0);
            reg_addr   = {3'($urandom), 2'b00};
            reg_wdata  = $urandom;
            cyc();
        end
        cyc(); cyc();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule